// File: doc/BRIEF.md
# Character Display Raster Timing Generator

This block produces the raster timing for a 40-column character display. It runs from a fast system clock and divides it into a pixel-rate clock enable. With the default 40 MHz clock and a divide ratio of 5, the pixel rate is 8 MHz. On each pixel enable a horizontal counter advances. When the horizontal counter wraps, a line counter advances. Every timing flag is decoded from these two counters: the text-area enable, the horizontal and vertical sync pulses, and a vertical-retrace level. A single-cycle interrupt request pulses on the rising edge of the retrace level, which gives a frame tick of about 60 Hz.

The retrace window does not start or end on line boundaries. It rises on the clock enable that moves the beam past the last displayed pixel of the bottom text row. It falls at the same horizontal position on the final line of the frame, which is the line just before the first text scanline. The window therefore covers exactly `V_TOTAL - V_ACTIVE` lines: bottom border, sync lines and top border. By default these are 20 lines each, 60 lines in all. The default frame is 512 pixel periods by 260 lines, with a 320 by 200 text area.

No data stream passes through this block. Every pin is a plain control or status signal with no valid/ready handshake and no back-pressure. A consumer samples the counters and flags in any cycle. The synchronous reset returns the raster to the top-left pixel. The enable freezes the raster while it is low.

Top module: `chardisp_timing`

## Requirements
- R1: `pix_en` is high for exactly one clock in every `PRESCALE` enabled clocks. After reset it is first high on the `PRESCALE`-th enabled clock.
- R2: `h_count` increments by one at each clock edge where `pix_en` is high, and wraps from `H_TOTAL-1` (`H_ACTIVE+H_FRONT+H_SYNC+H_BACK-1`) to 0.
- R3: `v_count` increments by one when `h_count` wraps, and wraps from `V_TOTAL-1` (`V_ACTIVE+2*V_BORDER+V_SYNC-1`) to 0. Neither counter changes on any other clock.
- R4: `disp_en` is high exactly when `h_count < H_ACTIVE` and `v_count < V_ACTIVE`.
- R5: `hsync` is high exactly when `H_ACTIVE+H_FRONT <= h_count < H_ACTIVE+H_FRONT+H_SYNC`.
- R6: `vsync` is high exactly when `V_ACTIVE+V_BORDER <= v_count < V_ACTIVE+V_BORDER+V_SYNC`.
- R7: `retrace` rises exactly when the counters reach `h_count == H_ACTIVE` with `v_count == V_ACTIVE-1`.
- R8: `retrace` falls exactly when the counters reach `h_count == H_ACTIVE` with `v_count == V_TOTAL-1`. It is therefore high for `(V_TOTAL-V_ACTIVE)*H_TOTAL` pixel periods.
- R9: `vblank_irq` is high for exactly one clock, in the clock where `retrace` first reads high, and is low at all other times.
- R10: While `en` is low, `pix_en` is low and the counters and the prescaler hold their values.
- R11: While `rst` is high at a clock edge, the counters, the prescaler and the retrace history are cleared. The outputs then read `h_count = 0`, `v_count = 0`, `pix_en = 0`, `vblank_irq = 0` and `disp_en = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low freezes the raster |
| pix_en | output | 1 | Pixel-rate clock enable |
| h_count | output | HW | Horizontal pixel position |
| v_count | output | VW | Line position |
| disp_en | output | 1 | Beam inside the text area |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| retrace | output | 1 | Vertical retrace level |
| vblank_irq | output | 1 | One-clock pulse when retrace rises |

## Verification
`pix_en` is a combinational function of `en` and the prescaler, so it is due in the same clock as the enable. The counters move at the edge where `pix_en` is high, and all decoded flags follow them in that same clock. `vblank_irq` is due in the clock right after that edge and is gone one edge later. The bench changes inputs at the falling edge. It advances its arithmetic model once per rising edge and compares every output at the next falling edge, so each result is sampled in the exact clock it is due. A small configuration is swept through several whole frames, including gated-enable stretches and a mid-frame reset, so that every pixel position is compared.

// File: rtl/ct_pkg.sv
package ct_pkg;

  // True when pos lies in the half-open span [lo, lo+len).
  function automatic logic in_span(input int pos, input int lo, input int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  typedef struct packed {
    logic disp_en;
    logic hsync;
    logic vsync;
    logic retrace;
  } ct_flags_t;

endpackage

// File: rtl/ct_pix_prescaler.sv
module ct_pix_prescaler #(
  parameter int PRESCALE = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic pix_en
);

  generate
    if (PRESCALE <= 1) begin : g_bypass
      assign pix_en = en;
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] C_LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst)
          cnt <= '0;
        else if (en)
          cnt <= (cnt == C_LAST) ? '0 : cnt + CW'(1);
      end

      assign pix_en = en && (cnt == C_LAST);

      // R1
      single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pix_en |=> !pix_en);
      // R10
      hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));
    end
  endgenerate

endmodule

// File: rtl/ct_raster_cnt.sv
module ct_raster_cnt #(
  parameter int H_TOTAL = 512,
  parameter int V_TOTAL = 260,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [HW-1:0] h,
  output logic [VW-1:0] v
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h <= '0;
      v <= '0;
    end else if (step) begin
      if (h == H_LAST) begin
        h <= '0;
        v <= (v == V_LAST) ? '0 : v + VW'(1);
      end else begin
        h <= h + HW'(1);
      end
    end
  end

  // R2
  h_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (step && h != H_LAST) |=> (h == $past(h) + HW'(1)) && $stable(v));
  // R3
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && h == H_LAST && v == V_LAST) |=> (h == '0) && (v == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(h) && $stable(v));
  // R3
  bounds_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(h) < H_TOTAL) && (int'(v) < V_TOTAL));

endmodule

// File: rtl/ct_frame_decode.sv
module ct_frame_decode
  import ct_pkg::*;
#(
  parameter int H_ACTIVE = 320,
  parameter int H_FRONT  = 32,
  parameter int H_SYNC   = 64,
  parameter int V_ACTIVE = 200,
  parameter int V_BORDER = 20,
  parameter int V_SYNC   = 20,
  parameter int HW       = 9,
  parameter int VW       = 9,
  localparam int V_TOTAL = V_ACTIVE + 2 * V_BORDER + V_SYNC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h,
  input  logic [VW-1:0] v,
  output ct_flags_t     flags,
  output logic          irq
);

  localparam int RISE_LINE = V_ACTIVE - 1;
  localparam int FALL_LINE = V_TOTAL - 1;

  int   hi, vi;
  logic retrace_q;

  always_comb begin
    hi = int'(h);
    vi = int'(v);
    flags.disp_en = in_span(hi, 0, H_ACTIVE) && in_span(vi, 0, V_ACTIVE);
    flags.hsync   = in_span(hi, H_ACTIVE + H_FRONT, H_SYNC);
    flags.vsync   = in_span(vi, V_ACTIVE + V_BORDER, V_SYNC);
    // Window opens right of the text area on the last text line and closes
    // at the same column on the final line of the frame.
    flags.retrace = ((vi > RISE_LINE) && (vi < FALL_LINE)) ||
                    ((vi == RISE_LINE) && (hi >= H_ACTIVE)) ||
                    ((vi == FALL_LINE) && (hi < H_ACTIVE));
  end

  always_ff @(posedge clk) begin
    if (rst)
      retrace_q <= 1'b0;
    else
      retrace_q <= flags.retrace;
  end

  assign irq = flags.retrace && !retrace_q;

  // R7
  rise_point_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flags.retrace) |-> (hi == H_ACTIVE) && (vi == RISE_LINE));
  // R8
  fall_point_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flags.retrace) |-> (hi == H_ACTIVE) && (vi == FALL_LINE));
  // R9
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R4
  text_not_blank_chk: assert property (@(posedge clk) disable iff (rst)
    flags.disp_en |-> !flags.retrace);

endmodule

// File: rtl/chardisp_timing.sv
module chardisp_timing
  import ct_pkg::*;
#(
  parameter int PRESCALE = 5,
  parameter int H_ACTIVE = 320,
  parameter int H_FRONT  = 32,
  parameter int H_SYNC   = 64,
  parameter int H_BACK   = 96,
  parameter int V_ACTIVE = 200,
  parameter int V_BORDER = 20,
  parameter int V_SYNC   = 20,
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
  localparam int V_TOTAL = V_ACTIVE + 2 * V_BORDER + V_SYNC,
  localparam int HW      = $clog2(H_TOTAL),
  localparam int VW      = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          pix_en,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic          disp_en,
  output logic          hsync,
  output logic          vsync,
  output logic          retrace,
  output logic          vblank_irq
);

  ct_flags_t flags;

  ct_pix_prescaler #(
    .PRESCALE(PRESCALE)
  ) u_presc (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .pix_en(pix_en)
  );

  ct_raster_cnt #(
    .H_TOTAL(H_TOTAL),
    .V_TOTAL(V_TOTAL)
  ) u_raster (
    .clk (clk),
    .rst (rst),
    .step(pix_en),
    .h   (h_count),
    .v   (v_count)
  );

  ct_frame_decode #(
    .H_ACTIVE(H_ACTIVE),
    .H_FRONT (H_FRONT),
    .H_SYNC  (H_SYNC),
    .V_ACTIVE(V_ACTIVE),
    .V_BORDER(V_BORDER),
    .V_SYNC  (V_SYNC),
    .HW      (HW),
    .VW      (VW)
  ) u_decode (
    .clk  (clk),
    .rst  (rst),
    .h    (h_count),
    .v    (v_count),
    .flags(flags),
    .irq  (vblank_irq)
  );

  assign disp_en = flags.disp_en;
  assign hsync   = flags.hsync;
  assign vsync   = flags.vsync;
  assign retrace = flags.retrace;

  // R10
  frozen_raster_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(h_count) && $stable(v_count) && !$past(pix_en));
  // R11
  reset_origin_chk: assert property (@(posedge clk)
    rst |=> (h_count == '0) && (v_count == '0) && !vblank_irq);

endmodule

// File: tb/chardisp_timing_tb_top.sv
`timescale 1ns/1ps
module chardisp_timing_tb_top;

  localparam int P  = 3;
  localparam int HA = 8, HF = 2, HS = 3, HB = 3;
  localparam int VA = 4, VB = 2, VS = 2;
  localparam int HT = HA + HF + HS + HB;   // 16
  localparam int VT = VA + 2 * VB + VS;    // 10
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, en = 1'b0;
  logic pix_en, disp_en, hsync, vsync, retrace, vblank_irq;
  logic [HW-1:0] h_count;
  logic [VW-1:0] v_count;

  chardisp_timing #(
    .PRESCALE(P), .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_BORDER(VB), .V_SYNC(VS)
  ) dut_i (
    .clk(clk), .rst(rst), .en(en), .pix_en(pix_en),
    .h_count(h_count), .v_count(v_count), .disp_en(disp_en),
    .hsync(hsync), .vsync(vsync), .retrace(retrace), .vblank_irq(vblank_irq)
  );

  int  checks = 0, errors = 0;
  int  n = 0;            // enabled clocks since reset
  bit  prev_vb = 0;      // expected retrace level before the last edge
  bit  last_rt = 0;      // observed retrace at previous sample
  int  rise_idx = -1;

  function automatic bit exp_vb(input int idx);
    int p, lo, hi;
    p  = idx % (HT * VT);
    lo = (VA - 1) * HT + HA;
    hi = (VT - 1) * HT + HA;
    return (p >= lo) && (p < hi);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (n=%0d)", req, act, exp, n);
    end
  endtask

  task automatic tick(input bit r, input bit e);
    int idx;
    rst = r;
    en  = e;
    @(posedge clk);
    if (r) begin
      n = 0;
      prev_vb = 0;
    end else begin
      prev_vb = exp_vb(n / P);
      if (e) n++;
    end
    @(negedge clk);
    idx = n / P;
    if (r) begin
      chk("R11 h", int'(h_count), 0);
      chk("R11 v", int'(v_count), 0);
      chk("R11 pix_en", int'(pix_en), 0);
      chk("R11 irq", int'(vblank_irq), 0);
      chk("R11 disp_en", int'(disp_en), 1);
      last_rt = 0;
      rise_idx = -1;
    end else begin
      chk(e ? "R1 pix_en" : "R10 pix_en", int'(pix_en),
          int'(e && (n % P == P - 1)));
      chk("R2 h", int'(h_count), idx % HT);
      chk("R3 v", int'(v_count), (idx / HT) % VT);
      chk("R4 disp_en", int'(disp_en),
          int'((idx % HT) < HA && ((idx / HT) % VT) < VA));
      chk("R5 hsync", int'(hsync),
          int'((idx % HT) >= HA + HF && (idx % HT) < HA + HF + HS));
      chk("R6 vsync", int'(vsync),
          int'(((idx / HT) % VT) >= VA + VB && ((idx / HT) % VT) < VA + VB + VS));
      chk("R7_R8 retrace", int'(retrace), int'(exp_vb(idx)));
      chk("R9 irq", int'(vblank_irq), int'(exp_vb(idx) && !prev_vb));
      if (retrace && !last_rt) begin
        chk("R7 rise h", int'(h_count), HA);
        chk("R7 rise v", int'(v_count), VA - 1);
        rise_idx = idx;
      end
      if (!retrace && last_rt) begin
        chk("R8 fall h", int'(h_count), HA);
        chk("R8 fall v", int'(v_count), VT - 1);
        if (rise_idx >= 0)
          chk("R8 length", idx - rise_idx, (VT - VA) * HT);
      end
      last_rt = retrace;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11: reset state, including reset taking priority over enable
    tick(1, 0);
    tick(1, 1);
    tick(1, 0);
    // R1..R9: free run over more than two frames
    repeat (2 * HT * VT * P + 50) tick(0, 1);
    // R10: gated enable pattern across a full frame and more
    for (int i = 0; i < 2 * HT * VT * P; i++)
      tick(0, (i % 7) != 3 && (i % 11) != 5);
    // R11: mid-frame reset, then a further full frame
    repeat (2) tick(1, 1);
    repeat (HT * VT * P + 20) tick(0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule